// File: doc/BRIEF.md
# Streaming ADPCM Encoder over a Shared 32-bit Memory

This block compresses a run of signed 16-bit audio samples, in place in memory, into 4-bit adaptive differential codes. A region of memory is split into two equal halves. The caller puts the samples in the upper half, two per 32-bit word, then pulses `start` with the region's base word address and the size of one half in words. The coder reads the sample words in ascending order and codes one sample per cycle. It packs eight codes into each 32-bit word and writes those words in ascending order from the base address. This overwrites the low half, which the samples never occupy. When the input runs out, any partly filled code word is written out, and then `done` rises.

Each code holds a sign bit and a 3-bit magnitude. The magnitude comes from comparing the difference between the sample and a running prediction against the current step size, then against half the step, then against a quarter of it. After every code the coder rebuilds the prediction from the quantised code, as a decoder would. It also moves a step-size index, and that index selects the next step size. Memory access uses a request/grant handshake: a read or write request is held, with the address and data steady, for as many cycles as the arbiter takes to grant it.

Top module: `adpcm_mem_coder`

## Requirements
- R1: After reset, `done`, `busy`, `mem_rd_req` and `mem_wr_req` are all 0.
- R2: Code bit 3 is 1 exactly when the sample is below the prediction. The magnitude m is |sample − prediction|. Code bit 2 is set when m ≥ step, and in that case step is subtracted from m. Bit 1 then compares the remainder against step>>1, and bit 0 compares it against step>>2, subtracting in the same way.
- R3: The rebuilt delta is step>>3, plus step, step>>1 and step>>2 for each of code bits 2, 1 and 0 that is set. This delta is subtracted from the prediction if bit 3 is set and added otherwise. The result is saturated to −32768..32767. Prediction and index both start at 0 on every `start`.
- R4: The index changes by −1, −1, −1, −1, +2, +4, +6 or +8 for code magnitudes 0 to 7, and is clamped to 0..88. The step table is step[0]=7, step[i]=min(32767, step[i−1]+max(1, step[i−1]/10)).
- R5: Sample words are read from base+half up to base+2·half−1 in ascending order. Bits 15:0 of each word hold the earlier sample.
- R6: Code k of a run goes to word base+k/8, at bits 4·(k mod 8)+3 : 4·(k mod 8). No other word is written.
- R7: If the code count is not a multiple of 8, the last word is written with its unused nibbles zero, and `done` rises only after that write has been granted. A run of half words writes exactly ceil(half/4) words.
- R8: A request stays asserted with a stable address (and stable write data) until `mem_gnt`. Read and write are never requested in the same cycle.
- R9: A word is read only once the input buffer is empty, so a run makes exactly `half` reads. A code word is written only when full or at the final flush.
- R10: `done` stays high, with no requests, until the next `start`. A `start` while busy is ignored. A run with half = 0 reaches `done` without any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when not busy) |
| region_base | input | AW | Word address of the region's low half |
| half_words | input | AW | Size of one half of the region, in words |
| mem_rd_req | output | 1 | Read request, held until granted |
| mem_wr_req | output | 1 | Write request, held until granted |
| mem_addr | output | AW | Word address of the current request |
| mem_wdata | output | 32 | Packed code word to write |
| mem_rdata | input | 32 | Read data, valid in the cycle `mem_gnt` grants a read |
| mem_gnt | input | 1 | Arbiter grant for the pending request |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has finished, held until the next start |

## Verification
The coder is run on full-range random samples, where codes of every magnitude and sign appear and the index moves widely. Runs of one repeated value show whether the prediction settles and the index falls back to its floor. Alternating full-scale extremes drive the prediction into saturation and the index into its upper clamp. A small random walk keeps the index near the bottom of the table. Directed short runs with hand-worked code words separate the sign path from the magnitude path. Region sizes that are and are not multiples of four words tell a full final word from a flushed partial one. Grant rates from always granted to rarely granted show that the buffering does not depend on the arbiter's latency.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;
    localparam int SMP_W     = 16;
    localparam int CODE_W    = 4;
    localparam int MEM_W     = 32;
    localparam int IDX_W     = 7;
    localparam int IDX_MAX   = 88;
    localparam int STEP_N    = IDX_MAX + 1;
    localparam int STEP_W    = 16;

    typedef logic [STEP_W-1:0] step_tbl_t [STEP_N];

    // Geometric step ladder, about ten percent per entry, never below +1.
    function automatic step_tbl_t build_steps();
        step_tbl_t t;
        int s;
        s = 7;
        for (int i = 0; i < STEP_N; i++) begin
            t[i] = STEP_W'(s);
            s = s + (((s / 10) > 1) ? (s / 10) : 1);
            if (s > 32767) s = 32767;
        end
        return t;
    endfunction

    // Index movement per code magnitude.
    function automatic logic signed [4:0] idx_adj(input logic [2:0] m);
        if (!m[2]) return -5'sd1;
        return $signed({2'b00, m[1:0], 1'b0}) + 5'sd2;
    endfunction
endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom
    import adpcm_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    output logic [STEP_W-1:0] step
);
    localparam step_tbl_t TBL = build_steps();

    always_comb begin
        if (int'(idx) > IDX_MAX) step = TBL[IDX_MAX];
        else                     step = TBL[idx];
    end
endmodule

// File: rtl/adpcm_quant.sv
module adpcm_quant
    import adpcm_pkg::*;
(
    input  logic signed [SMP_W-1:0] sample,
    input  logic signed [SMP_W-1:0] pred,
    input  logic [IDX_W-1:0]        idx,
    output logic [CODE_W-1:0]       code,
    output logic signed [SMP_W-1:0] pred_nx,
    output logic [IDX_W-1:0]        idx_nx
);
    logic [STEP_W-1:0]        step;
    logic signed [SMP_W:0]    diff;
    logic [SMP_W:0]           rem, vp, thr;
    logic                     neg;
    logic [2:0]               mag;
    logic signed [SMP_W+2:0]  psum;
    logic signed [IDX_W+1:0]  isum;

    adpcm_step_rom u_rom (.idx(idx), .step(step));

    always_comb begin
        diff = $signed({sample[SMP_W-1], sample}) - $signed({pred[SMP_W-1], pred});
        neg  = diff[SMP_W];
        rem  = neg ? (~diff + 1'b1) : diff;
        vp   = {1'b0, step} >> 3;
        mag  = '0;
        for (int b = 2; b >= 0; b--) begin
            thr = {1'b0, step} >> (2 - b);
            if (rem >= thr) begin
                mag[b] = 1'b1;
                rem    = rem - thr;
                vp     = vp + thr;
            end
        end
        code = {neg, mag};

        if (neg) psum = $signed({{2{pred[SMP_W-1]}}, pred[SMP_W-1], pred}) - $signed({2'b00, vp});
        else     psum = $signed({{2{pred[SMP_W-1]}}, pred[SMP_W-1], pred}) + $signed({2'b00, vp});
        if (psum > 19'sd32767)       pred_nx = 16'sh7FFF;
        else if (psum < -19'sd32768) pred_nx = 16'sh8000;
        else                         pred_nx = psum[SMP_W-1:0];

        isum = $signed({2'b00, idx}) + (IDX_W+2)'(idx_adj(mag));
        if (isum < 0)                          idx_nx = '0;
        else if (isum > (IDX_W+2)'(IDX_MAX))   idx_nx = IDX_W'(IDX_MAX);
        else                                   idx_nx = isum[IDX_W-1:0];
    end
endmodule

// File: rtl/adpcm_mem_coder.sv
module adpcm_mem_coder
    import adpcm_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    region_base,
    input  logic [AW-1:0]    half_words,
    output logic             mem_rd_req,
    output logic             mem_wr_req,
    output logic [AW-1:0]    mem_addr,
    output logic [MEM_W-1:0] mem_wdata,
    input  logic [MEM_W-1:0] mem_rdata,
    input  logic             mem_gnt,
    output logic             busy,
    output logic             done
);
    localparam int NIB_PER_WORD = MEM_W / CODE_W;
    localparam int NW           = $clog2(NIB_PER_WORD) + 1;
    localparam int SMP_PER_WORD = MEM_W / SMP_W;

    typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_CODE, ST_WRITE, ST_DONE} cst_e;

    typedef struct packed {
        cst_e              st;
        logic [AW-1:0]     rd_ptr;
        logic [AW-1:0]     wr_ptr;
        logic [AW-1:0]     left;
        logic [MEM_W-1:0]  inbuf;
        logic [1:0]        in_cnt;
        logic [MEM_W-1:0]  outbuf;
        logic [NW-1:0]     nib;
        logic [SMP_W-1:0]  pred;
        logic [IDX_W-1:0]  idx;
    } cst_t;

    cst_t s_d, s_q;

    logic signed [SMP_W-1:0] cur_smp, pred_nx;
    logic [CODE_W-1:0]       code;
    logic [IDX_W-1:0]        idx_nx;

    assign cur_smp = (s_q.in_cnt == 2'(SMP_PER_WORD)) ? s_q.inbuf[SMP_W-1:0]
                                                      : s_q.inbuf[MEM_W-1:SMP_W];

    adpcm_quant u_quant (
        .sample (cur_smp),
        .pred   (s_q.pred),
        .idx    (s_q.idx),
        .code   (code),
        .pred_nx(pred_nx),
        .idx_nx (idx_nx)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    s_d.rd_ptr = region_base + half_words;
                    s_d.wr_ptr = region_base;
                    s_d.left   = half_words;
                    s_d.in_cnt = '0;
                    s_d.outbuf = '0;
                    s_d.nib    = '0;
                    s_d.pred   = '0;
                    s_d.idx    = '0;
                    s_d.st     = (half_words == '0) ? ST_DONE : ST_READ;
                end
            end
            ST_READ: begin
                if (mem_gnt) begin
                    s_d.inbuf  = mem_rdata;
                    s_d.in_cnt = 2'(SMP_PER_WORD);
                    s_d.rd_ptr = s_q.rd_ptr + 1'b1;
                    s_d.left   = s_q.left - 1'b1;
                    s_d.st     = ST_CODE;
                end
            end
            ST_CODE: begin
                s_d.outbuf[s_q.nib[NW-2:0]*CODE_W +: CODE_W] = code;
                s_d.nib    = s_q.nib + 1'b1;
                s_d.in_cnt = s_q.in_cnt - 1'b1;
                s_d.pred   = pred_nx;
                s_d.idx    = idx_nx;
                if (s_q.nib == NW'(NIB_PER_WORD - 1))
                    s_d.st = ST_WRITE;
                else if (s_q.in_cnt == 2'd1)
                    s_d.st = (s_q.left == '0) ? ST_WRITE : ST_READ;
                else
                    s_d.st = ST_CODE;
            end
            ST_WRITE: begin
                if (mem_gnt) begin
                    s_d.wr_ptr = s_q.wr_ptr + 1'b1;
                    s_d.outbuf = '0;
                    s_d.nib    = '0;
                    if (s_q.in_cnt != '0)    s_d.st = ST_CODE;
                    else if (s_q.left != '0) s_d.st = ST_READ;
                    else                     s_d.st = ST_DONE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_rd_req = (s_q.st == ST_READ);
    assign mem_wr_req = (s_q.st == ST_WRITE);
    assign mem_addr   = (s_q.st == ST_WRITE) ? s_q.wr_ptr : s_q.rd_ptr;
    assign mem_wdata  = s_q.outbuf;
    assign busy       = (s_q.st == ST_READ) || (s_q.st == ST_CODE) || (s_q.st == ST_WRITE);
    assign done       = (s_q.st == ST_DONE);
endmodule

// File: rtl/adpcm_coder_chk.sv
module adpcm_coder_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_rd_req,
    input logic          mem_wr_req,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_gnt,
    input logic          busy,
    input logic          done
);
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!mem_rd_req && !mem_wr_req && !done && !busy)
                else $error("outputs active during reset");
        end
    end

    assert_one_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    assert_hold_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_gnt) |=> (mem_rd_req && $stable(mem_addr)));

    assert_hold_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_gnt) |=> (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata)));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_rd_req && !mem_wr_req && !busy));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_busy_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_gnt && start) |=> !($fell(busy) && !done));
endmodule

bind adpcm_mem_coder adpcm_coder_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_adpcm_mem_coder.sv
`timescale 1ns/1ps
module sim_adpcm_mem_coder;
    localparam int AW = 16;
    localparam int MEMN = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] region_base = '0;
    logic [AW-1:0] half_words = '0;
    logic          mem_rd_req, mem_wr_req, busy, done;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_gnt = 1'b0;

    adpcm_mem_coder #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .region_base(region_base), .half_words(half_words),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [31:0] mem [MEMN];
    int gnt_pct = 100;
    int rd_cnt, wr_cnt, late_acc, rd_order_bad, exp_rd_addr;
    int cycles = 0;
    int steps [89];
    int adj [8] = '{-1, -1, -1, -1, 2, 4, 6, 8};
    int m_pred, m_idx;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory and arbiter model, driven away from the active edge
    always @(negedge clk) begin
        mem_gnt <= 1'b0;
        if (rst_n) begin
            if (done && (mem_rd_req || mem_wr_req)) late_acc++;
            if ((mem_rd_req || mem_wr_req) && ($urandom_range(99) < gnt_pct)) begin
                mem_gnt <= 1'b1;
                if (mem_rd_req) begin
                    mem_rdata <= mem[mem_addr[7:0]];
                    rd_cnt++;
                    if (int'(mem_addr) != exp_rd_addr) rd_order_bad++;
                    exp_rd_addr++;
                end else begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_cnt++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", "run did not finish", cycles, 150000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int model_code(input int s);
        int d, st, c, v;
        bit sg;
        d = s - m_pred;
        sg = (d < 0);
        if (sg) d = -d;
        st = steps[m_idx];
        c = 0;
        v = st / 8;
        if (d >= st)     begin c += 4; d -= st;     v += st;     end
        if (d >= st / 2) begin c += 2; d -= st / 2; v += st / 2; end
        if (d >= st / 4) begin c += 1;               v += st / 4; end
        m_pred = sg ? m_pred - v : m_pred + v;
        if (m_pred > 32767) m_pred = 32767;
        if (m_pred < -32768) m_pred = -32768;
        m_idx += adj[c];
        if (m_idx < 0) m_idx = 0;
        if (m_idx > 88) m_idx = 88;
        return c + (sg ? 8 : 0);
    endfunction

    function automatic logic [15:0] gen_sample(input int mode, input int k);
        case (mode)
            0: return 16'($urandom);
            1: return 16'sd1234;
            2: return (k % 2) ? 16'h8000 : 16'h7FFF;
            default: return 16'(($urandom_range(40) - 20) * (k % 7));
        endcase
    endfunction

    task automatic run_case(input int base, input int half, input int pct,
                            input int mode, input bit poke, input string tag);
        logic [31:0] expw [64];
        logic [31:0] snap [MEMN];
        int nw, cyc, badw, badk;
        bit seen, held;
        for (int i = 0; i < MEMN; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
        for (int w = 0; w < half; w++)
            mem[base + half + w] = {gen_sample(mode, 2*w+1), gen_sample(mode, 2*w)};
        for (int i = 0; i < MEMN; i++) snap[i] = mem[i];
        m_pred = 0; m_idx = 0;
        nw = (2*half + 7) / 8;
        for (int i = 0; i < 64; i++) expw[i] = '0;
        for (int k = 0; k < 2*half; k++) begin
            logic [31:0] wd;
            wd = snap[base + half + k/2];
            expw[k/8][4*(k%8) +: 4] = 4'(model_code(int'($signed((k % 2) ? wd[31:16] : wd[15:0]))));
        end
        for (int i = 0; i < nw; i++) snap[base + i] = expw[i];

        gnt_pct = pct; rd_cnt = 0; wr_cnt = 0; late_acc = 0; rd_order_bad = 0;
        exp_rd_addr = base + half;
        @(negedge clk);
        region_base = AW'(base); half_words = AW'(half); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 6);
        end
        start = 1'b0;
        seen = done;
        chk(seen, "R10", {tag, " done reached"}, seen, 1);
        held = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!done || busy) held = 1'b0;
        end
        chk(held && late_acc == 0, "R10", {tag, " done held, no access after"}, late_acc, 0);
        chk(rd_cnt == half, "R9", {tag, " read count"}, rd_cnt, half);
        chk(rd_order_bad == 0, "R5", {tag, " read address order"}, rd_order_bad, 0);
        chk(wr_cnt == nw, "R7", {tag, " write count incl flush"}, wr_cnt, nw);
        badw = 0; badk = -1;
        for (int i = 0; i < MEMN; i++)
            if (mem[i] !== snap[i]) begin badw++; if (badk < 0) badk = i; end
        if (badk < 0) badk = 0;
        chk(badw == 0, "R6", {tag, " memory image (codes R2 R3 R4)"}, mem[badk], snap[badk]);
    endtask

    initial begin
        int s;
        void'($urandom(32'd2024));
        s = 7;
        for (int i = 0; i < 89; i++) begin
            steps[i] = s;
            s = s + ((s / 10 > 1) ? s / 10 : 1);
            if (s > 32767) s = 32767;
        end
        for (int i = 0; i < MEMN; i++) mem[i] = '0;

        #12;
        chk(!done && !busy && !mem_rd_req && !mem_wr_req, "R1", "reset outputs",
            {done, busy, mem_rd_req, mem_wr_req}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy, "R1", "idle after reset", {done, busy}, 0);

        // directed: samples 0 then 100 -> codes 0, 7
        for (int i = 0; i < MEMN; i++) mem[i] = '0;
        mem[11] = {16'd100, 16'd0};
        gnt_pct = 100; rd_cnt = 0; wr_cnt = 0; late_acc = 0; rd_order_bad = 0; exp_rd_addr = 11;
        region_base = 16'd10; half_words = 16'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        chk(mem[10] == 32'h0000_0070, "R2", "magnitude code word", mem[10], 32'h70);

        // directed: -100 twice -> codes F, F (R3 prediction to -11, R4 index to 8)
        mem[21] = {16'hFF9C, 16'hFF9C};
        rd_cnt = 0; wr_cnt = 0; exp_rd_addr = 21;
        region_base = 16'd20; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        chk(mem[20] == 32'h0000_00FF, "R2", "sign code word", mem[20], 32'hFF);

        // empty region
        rd_cnt = 0; wr_cnt = 0; late_acc = 0;
        half_words = 16'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(done && rd_cnt == 0 && wr_cnt == 0, "R10", "zero-size run", rd_cnt + wr_cnt, 0);

        run_case(4,   4, 100, 1, 1'b0, "constant exact");
        run_case(0,   1,  50, 0, 1'b0, "one word flush");
        run_case(30, 13,  30, 2, 1'b0, "extremes sat");
        run_case(60, 20,  70, 3, 1'b1, "walk start-while-busy");
        for (int r = 0; r < 6; r++)
            run_case($urandom_range(40), $urandom_range(24) + 1, $urandom_range(90) + 10,
                     0, 1'b0, "random");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule